// File: doc/BRIEF.md
# NAND Page Hamming Parity Generator

This block sits in the data path between a NAND flash device and memory and builds Hamming parity while page bytes stream through it, one byte per clock. Each byte carries an 11-bit address within its 256-byte chunk. The upper eight address bits are the byte index and the lower three are the bit position inside the byte. For every chunk the block keeps two parity words. One is the XOR of all data bits whose address has a given bit set, and the other is the XOR of the bits whose address has that bit clear.

Software or a later stage compares these words with parity saved on a previous pass. The XOR of the two sets locates a single flipped bit, and patterns that do not fit a single flip show that more bits are corrupted. In half-page mode (256 bytes) only the first pair accumulates. In full-page mode (512 bytes) the second 256 bytes go to a separate pair. The mode input must be held constant for the whole transfer. A synchronous clear starts every transfer from zero.

Top module: `nand_ecc_gen`

## Requirements
- R1: After the asynchronous reset (rst_ni low), all four parity outputs are zero and done_o is low.
- R2: Bit k of the "set" word (ecc0_o, or ecc2_o for the second half) is the XOR of every accepted data bit whose address {byte index within the chunk [7:0], bit index [2:0]} has bit k equal to 1. Address bits [2:0] are the bit position of data_i and bits [10:3] are the byte index.
- R3: Bit k of the "clear" word (ecc1_o, or ecc3_o for the second half) is the XOR of every accepted data bit whose address has bit k equal to 0.
- R4: With mode512_i=0, all bytes accumulate into ecc0_o and ecc1_o, and ecc2_o and ecc3_o stay zero. done_o rises after the 256th accepted byte.
- R5: With mode512_i=1, bytes 0 to 255 accumulate into ecc0_o and ecc1_o. Bytes 256 to 511 accumulate into ecc2_o and ecc3_o, with a byte index of (byte number - 256). done_o rises after the 512th accepted byte.
- R6: One byte is accepted on each clock edge where valid_i is high. While valid_i is low, all parity outputs hold their values.
- R7: done_o is registered. It goes high on the clock edge that accepts the final byte and stays high until a clear. Bytes presented while done_o is high are ignored and leave every output unchanged.
- R8: clr_i is synchronous. On the next clock edge it zeros all parity words, the byte count and done_o, and it takes priority over valid_i.
- R9: Flipping one data bit at address A changes the set word of that half by exactly A and the clear word by exactly (A XOR 0x7FF). The other half does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Synchronous clear of parity, count and done |
| mode512_i | input | 1 | 0: 256-byte page, 1: 512-byte page in two halves |
| valid_i | input | 1 | data_i holds a byte to accept this cycle |
| data_i | input | 8 | Page data byte |
| ecc0_o | output | 11 | First half, address-bit-set parity |
| ecc1_o | output | 11 | First half, address-bit-clear parity |
| ecc2_o | output | 11 | Second half, address-bit-set parity |
| ecc3_o | output | 11 | Second half, address-bit-clear parity |
| done_o | output | 1 | Page complete, held until clear |

## Verification
An all-zero page shows that nothing accumulates without data. A page with one set bit at a known address pins the exact mapping of the byte index and the bit index onto the parity bits. Pseudo-random pages in both modes are checked against an independent model, which tells apart a wrong half split, a wrong index within the second half and a swapped set/clear word. The same random page is then run again with one bit flipped, and a mid-page stall, trailing bytes after completion and a clear raised together with valid separate the hold, ignore and priority rules.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned IDX_W     = 8;
  localparam int unsigned BIT_AW    = $clog2(BYTE_W);
  localparam int unsigned ECC_W     = IDX_W + BIT_AW;
  localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/nand_ecc_term.sv
// Parity contribution of one byte; BYTE_W must be a power of two.
module nand_ecc_term #(
  parameter int unsigned BYTE_W = nand_ecc_pkg::BYTE_W,
  parameter int unsigned IDX_W  = nand_ecc_pkg::IDX_W,
  localparam int unsigned BIT_AW = $clog2(BYTE_W),
  localparam int unsigned ECC_W  = IDX_W + BIT_AW
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [ECC_W-1:0]  set_o,
  output logic [ECC_W-1:0]  clr_o
);
  logic par;
  assign par = ^data_i;

  for (genvar gk = 0; gk < BIT_AW; gk++) begin : g_bitpos
    logic [BYTE_W-1:0] mask;
    for (genvar gb = 0; gb < BYTE_W; gb++) begin : g_mask
      assign mask[gb] = ((gb >> gk) & 1) == 1;
    end
    assign set_o[gk] = ^(data_i & mask);
    assign clr_o[gk] = ^(data_i & ~mask);
  end

  for (genvar gj = 0; gj < IDX_W; gj++) begin : g_idx
    assign set_o[BIT_AW+gj] = idx_i[gj] & par;
    assign clr_o[BIT_AW+gj] = ~idx_i[gj] & par;
  end
endmodule

// File: rtl/nand_ecc_ctrl.sv
module nand_ecc_ctrl #(
  parameter int unsigned IDX_W = nand_ecc_pkg::IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             valid_i,
  input  logic             mode512_i,
  output logic             acc_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             bank_o,
  output logic             done_o
);
  logic [IDX_W:0] cnt_q;
  logic           last;

  assign acc_o  = valid_i & ~done_o & ~clr_i;
  assign last   = mode512_i ? (&cnt_q) : (&cnt_q[IDX_W-1:0]);
  assign idx_o  = cnt_q[IDX_W-1:0];
  assign bank_o = mode512_i & cnt_q[IDX_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (acc_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (last) done_o <= 1'b1;
    end
  end

  // R7
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !clr_i |=> done_o);
  // R7
  done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(valid_i) && !$past(clr_i));
  // R8
  clr_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !done_o && idx_o == '0);
endmodule

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc #(
  parameter int unsigned ECC_W = nand_ecc_pkg::ECC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [ECC_W-1:0] set_term_i,
  input  logic [ECC_W-1:0] clr_term_i,
  output logic [ECC_W-1:0] set_o,
  output logic [ECC_W-1:0] clr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_o <= '0;
      clr_o <= '0;
    end else if (clr_i) begin
      set_o <= '0;
      clr_o <= '0;
    end else if (en_i) begin
      set_o <= set_o ^ set_term_i;
      clr_o <= clr_o ^ clr_term_i;
    end
  end

  // R8
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> set_o == '0 && clr_o == '0);
  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !clr_i |=> $stable(set_o) && $stable(clr_o));
endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen #(
  parameter int unsigned BYTE_W = nand_ecc_pkg::BYTE_W,
  parameter int unsigned IDX_W  = nand_ecc_pkg::IDX_W,
  localparam int unsigned ECC_W = IDX_W + $clog2(BYTE_W),
  localparam int unsigned NB    = nand_ecc_pkg::NUM_BANKS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              mode512_i,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [ECC_W-1:0]  ecc0_o,
  output logic [ECC_W-1:0]  ecc1_o,
  output logic [ECC_W-1:0]  ecc2_o,
  output logic [ECC_W-1:0]  ecc3_o,
  output logic              done_o
);
  logic             acc;
  logic             bank;
  logic [IDX_W-1:0] idx;
  logic [ECC_W-1:0] set_term, clr_term;
  logic [ECC_W-1:0] bank_set [NB];
  logic [ECC_W-1:0] bank_clr [NB];

  nand_ecc_ctrl #(.IDX_W(IDX_W)) ctrl_i (
    .clk_i, .rst_ni, .clr_i, .valid_i, .mode512_i,
    .acc_o(acc), .idx_o(idx), .bank_o(bank), .done_o
  );

  nand_ecc_term #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) term_i (
    .idx_i(idx), .data_i, .set_o(set_term), .clr_o(clr_term)
  );

  for (genvar gi = 0; gi < NB; gi++) begin : g_bank
    logic en;
    assign en = acc & (bank == (gi != 0));
    nand_ecc_acc #(.ECC_W(ECC_W)) acc_i (
      .clk_i, .rst_ni, .clr_i, .en_i(en),
      .set_term_i(set_term), .clr_term_i(clr_term),
      .set_o(bank_set[gi]), .clr_o(bank_clr[gi])
    );
  end

  assign ecc0_o = bank_set[0];
  assign ecc1_o = bank_clr[0];
  assign ecc2_o = bank_set[1];
  assign ecc3_o = bank_clr[1];

  // R3 the two sets stay complementary: an odd byte flips every bit of their XOR
  compl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !done_o && !clr_i && (^data_i) && !bank |=>
      (ecc0_o ^ ecc1_o) == ($past(ecc0_o ^ ecc1_o) ^ {ECC_W{1'b1}}));
  // R4
  upper_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode512_i && !clr_i |=> $stable(ecc2_o) && $stable(ecc3_o));
  // R7
  ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !clr_i |=> $stable(ecc0_o) && $stable(ecc2_o));
endmodule

// File: tb/nand_ecc_gen_tb_top.sv
`timescale 1ns/1ps
module nand_ecc_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clr_i = 1'b0;
  logic        mode512_i = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  data_i = '0;
  logic [10:0] ecc0_o, ecc1_o, ecc2_o, ecc3_o;
  logic        done_o;

  typedef struct {
    logic [10:0] e [4];
    string       req;
  } exp_t;

  exp_t        exp_q [$];
  int          total = 0;
  int          bad = 0;
  logic [7:0]  pg [512];
  logic [10:0] snap [4];
  logic        done_q = 1'b0;

  always #2.5 clk_i = ~clk_i;

  nand_ecc_gen dut_i (
    .clk_i, .rst_ni, .clr_i, .mode512_i, .valid_i, .data_i,
    .ecc0_o, .ecc1_o, .ecc2_o, .ecc3_o, .done_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic exp_t model(input bit m512, input string req);
    exp_t r;
    int n = m512 ? 512 : 256;
    for (int k = 0; k < 4; k++) r.e[k] = '0;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++)
        if (pg[i][b]) begin
          logic [10:0] a;
          int bk;
          a  = {i[7:0], b[2:0]};
          bk = (m512 && i >= 256) ? 2 : 0;
          r.e[bk]   ^= a;
          r.e[bk+1] ^= a ^ 11'h7FF;
        end
    r.req = req;
    return r;
  endfunction

  // monitor: on each rising done, compare with the next expected page
  always @(negedge clk_i) begin
    if (rst_ni && done_o && !done_q) begin
      if (exp_q.size() == 0) chk(1'b0, "R7 unexpected done", 32'(done_o), 0);
      else begin
        exp_t x;
        x = exp_q.pop_front();
        chk(ecc0_o == x.e[0], {x.req, " ecc0"}, 32'(ecc0_o), 32'(x.e[0]));
        chk(ecc1_o == x.e[1], {x.req, " ecc1"}, 32'(ecc1_o), 32'(x.e[1]));
        chk(ecc2_o == x.e[2], {x.req, " ecc2"}, 32'(ecc2_o), 32'(x.e[2]));
        chk(ecc3_o == x.e[3], {x.req, " ecc3"}, 32'(ecc3_o), 32'(x.e[3]));
      end
    end
    done_q = done_o;
  end

  task automatic do_clear(input bit with_valid);
    @(negedge clk_i);
    clr_i = 1'b1; valid_i = with_valid; data_i = 8'hA5;
    @(negedge clk_i);
    clr_i = 1'b0; valid_i = 1'b0;
    chk(ecc0_o == 0 && ecc1_o == 0 && ecc2_o == 0 && ecc3_o == 0, "R8 clear zeros",
        32'(ecc0_o | ecc1_o | ecc2_o | ecc3_o), 0);
    chk(!done_o, "R8 clear done", 32'(done_o), 0);
  endtask

  task automatic take_snap();
    snap[0] = ecc0_o; snap[1] = ecc1_o; snap[2] = ecc2_o; snap[3] = ecc3_o;
  endtask

  // driver: push expected, then stream bytes; optional stall after byte gap_at
  task automatic run_page(input bit m512, input string req, input int gap_at);
    int n = m512 ? 512 : 256;
    exp_q.push_back(model(m512, req));
    mode512_i = m512;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b1; data_i = pg[i];
      if (i == gap_at) begin
        @(negedge clk_i);
        valid_i = 1'b0;
        take_snap();
        repeat (3) @(negedge clk_i);
        chk(ecc0_o == snap[0] && ecc2_o == snap[2] && ecc3_o == snap[3], "R6 hold while idle",
            32'(ecc2_o), 32'(snap[2]));
        chk(!done_o, "R6 no done mid page", 32'(done_o), 0);
      end
    end
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(done_o, {req, " done after last byte"}, 32'(done_o), 1);
    @(negedge clk_i);
  endtask

  task automatic fill_rand(input int unsigned seed);
    int unsigned x = seed;
    for (int i = 0; i < 512; i++) begin
      x = x * 32'd1103515245 + 32'd12345;
      pg[i] = x[23:16];
    end
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(ecc0_o == 0 && ecc1_o == 0 && ecc2_o == 0 && ecc3_o == 0, "R1 reset parity",
        32'(ecc0_o | ecc1_o | ecc2_o | ecc3_o), 0);
    chk(!done_o, "R1 reset done", 32'(done_o), 0);
    rst_ni = 1'b1;

    // all-zero page, 256 mode
    for (int i = 0; i < 512; i++) pg[i] = 8'h00;
    do_clear(1'b0);
    run_page(1'b0, "R4 zero page", -1);

    // single bit at byte 0x5A bit 3 -> address 0x2D3
    pg[8'h5A] = 8'h08;
    do_clear(1'b0);
    run_page(1'b0, "R2 R3 single bit", -1);
    chk(ecc0_o == 11'h2D3, "R2 set word of single bit", 32'(ecc0_o), 32'h2D3);
    chk(ecc1_o == 11'h52C, "R3 clear word of single bit", 32'(ecc1_o), 32'h52C);

    // random 512 page with a stall in the second half
    fill_rand(32'h1234_5678);
    do_clear(1'b0);
    run_page(1'b1, "R5 random 512", 300);
    take_snap();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      valid_i = 1'b1; data_i = 8'hFF - 8'(i);
    end
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(ecc0_o == snap[0] && ecc1_o == snap[1], "R7 bytes after done ignored lo",
        32'(ecc0_o), 32'(snap[0]));
    chk(ecc2_o == snap[2] && ecc3_o == snap[3], "R7 bytes after done ignored hi",
        32'(ecc2_o), 32'(snap[2]));
    chk(done_o, "R7 done held", 32'(done_o), 1);

    // same page with one flipped bit: byte 451 (half 1, index 0xC3) bit 6 -> 0x61E
    pg[451] = pg[451] ^ 8'h40;
    do_clear(1'b1);
    run_page(1'b1, "R9 flipped page", -1);
    chk((ecc2_o ^ snap[2]) == 11'h61E, "R9 set syndrome", 32'(ecc2_o ^ snap[2]), 32'h61E);
    chk((ecc3_o ^ snap[3]) == 11'h1E1, "R9 clear syndrome", 32'(ecc3_o ^ snap[3]), 32'h1E1);
    chk(ecc0_o == snap[0] && ecc1_o == snap[1], "R9 other half unchanged",
        32'(ecc0_o), 32'(snap[0]));

    // random 256 page, upper words must stay zero
    fill_rand(32'hCAFE_0042);
    do_clear(1'b1);
    run_page(1'b0, "R4 random 256", 100);
    do_clear(1'b0);

    chk(exp_q.size() == 0, "R7 every page completed", 32'(exp_q.size()), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule